// File: doc/BRIEF.md
# Ethernet Frame Classifier and Router

This block takes Ethernet frames in on a 64-bit valid/ready stream and sends each whole frame to one of three places. Frames arriving here carry six zero bytes ahead of the destination address, so the IPv4 and UDP fields fall on fixed positions of the 64-bit beats. The block holds the first six beats, which make up the complete padded Ethernet, IPv4 and UDP header. From those beats it takes one routing decision per frame. It then either strips the header and streams the UDP payload out, or replays the whole frame to a processor port, or replays it to a crossover port that leads to a second Ethernet interface.

The addresses to match are supplied on plain input pins: the device MAC, a bridge-mode MAC, one IPv4 address and two UDP ports. Two settings registers, written over a strobe/address/32-bit-data bus, switch the payload path, bridge matching and each UDP port on or off. A build option, `DROP_FOREIGN`, chooses what happens to frames for other MAC addresses: they are forwarded to the crossover port (the default), or they are consumed and discarded.

Every stream follows the usual rules. A beat moves on a cycle where valid and ready are both high. An output that has raised valid keeps its beat unchanged until ready is seen. When the chosen output stalls, `in_ready` goes low, so back-pressure reaches the source one frame at a time and no beat is lost. Checksums, ARP and fragments are not examined.

Top module: `eth_frame_router`

## Requirements
- R1: After reset all three output valids are low and `in_ready` is high. The settings take their defaults: payload path on, bridge match on, both UDP ports on.
- R2: Beat byte 0 is bits [63:56]. Destination MAC = {beat0[15:0], beat1[63:32]}. The remaining fields are: ethertype in beat2[47:32] (0x0800), IP protocol in beat3[23:16] (17), destination IP in beat4[31:0], destination UDP port in beat5[47:32]. A frame is fully matched when all of these hold: its MAC equals `own_mac` (or `alt_mac` with bridge match on), all its fields match, and it is longer than six beats. Such a frame leaves on the stream output as beats 6 onward only, unchanged, in order, with `strm_last` on the final beat.
- R3: A frame to `own_mac` or an enabled `alt_mac` that is not fully matched goes to the CPU output whole, pad beat included. This covers a wrong ethertype, wrong protocol, wrong IP or wrong port. Each beat keeps its data and tuser, with `cpu_last` on the final beat.
- R4: A frame to the broadcast MAC (all ones) goes to the CPU output whole, even when its UDP fields match.
- R5: A frame whose MAC matches neither address goes to the crossover output whole with its tuser when `DROP_FOREIGN` is 0. When `DROP_FOREIGN` is 1, the frame is accepted and discarded.
- R6: A write to `SET_BASE` sets bit 0 = payload path enable and bit 1 = bridge match enable. With bit 0 clear, fully matched frames go to the CPU output. With bit 1 clear, frames to `alt_mac` are treated as foreign.
- R7: A write to `SET_BASE`+1 sets bit 0 = `port_a` enable and bit 1 = `port_b` enable; a disabled port never matches. Writes to any other address have no effect.
- R8: At most one output is valid at a time. A valid beat stays valid and unchanged until ready. While the selected output is stalled, `in_ready` is low. No beat is dropped or duplicated under any ready pattern.
- R9: The destination is fixed once the header is held and stays until the frame's last beat. A settings write in the middle of a frame affects only later frames.
- R10: A frame whose last beat is within the first six beats is never sent to the stream output. If it reaches the destination MAC (two beats or more) and matches, it goes to the CPU. If it has only one beat, it is treated as foreign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_stb | input | 1 | Settings write strobe |
| set_addr | input | SET_AW | Settings write address |
| set_data | input | 32 | Settings write data |
| own_mac | input | 48 | Device MAC address |
| alt_mac | input | 48 | Bridge-mode MAC address |
| own_ip | input | 32 | Device IPv4 address |
| port_a | input | 16 | First UDP port to match |
| port_b | input | 16 | Second UDP port to match |
| in_data | input | 64 | Incoming frame beat |
| in_user | input | UW | Incoming beat sideband |
| in_last | input | 1 | Last beat of incoming frame |
| in_valid | input | 1 | Incoming beat valid |
| in_ready | output | 1 | Incoming beat accepted |
| strm_data | output | 64 | UDP payload beat |
| strm_last | output | 1 | Last payload beat |
| strm_valid | output | 1 | Payload beat valid |
| strm_ready | input | 1 | Payload sink ready |
| cpu_data | output | 64 | CPU frame beat |
| cpu_user | output | UW | CPU beat sideband |
| cpu_last | output | 1 | Last CPU beat |
| cpu_valid | output | 1 | CPU beat valid |
| cpu_ready | input | 1 | CPU sink ready |
| xo_data | output | 64 | Crossover frame beat |
| xo_user | output | UW | Crossover beat sideband |
| xo_last | output | 1 | Last crossover beat |
| xo_valid | output | 1 | Crossover beat valid |
| xo_ready | input | 1 | Crossover sink ready |

## Verification
A table of frames varies one header field at a time: MAC kind, ethertype, protocol, IP and port. Each entry differs from a fully matched frame in a single field, so a wrong route points straight at the comparison that failed. Frames of one, three and six beats show that the header-length guard takes priority over field matching. Register writes, including one to an unused address, show which match term each setting gates. A stalled payload sink, combined with a settings write in the middle of that frame, separates per-frame route latching from live decoding. Random ready patterns on all three sinks show that no beat is lost or repeated.

// File: rtl/eth_route_pkg.sv
package eth_route_pkg;
  localparam int BEAT_W    = 64;
  localparam int HDR_BEATS = 6;
  localparam int IDX_W     = $clog2(HDR_BEATS + 1);

  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam logic [7:0]  PROTO_UDP  = 8'd17;

  typedef enum logic [1:0] {
    DEST_STRM = 2'd0,
    DEST_CPU  = 2'd1,
    DEST_XO   = 2'd2,
    DEST_DROP = 2'd3
  } dest_e;

  typedef enum logic [1:0] {
    S_CAPT,
    S_DECIDE,
    S_REPLAY,
    S_PASS
  } phase_e;

  typedef struct packed {
    logic       strm_en;
    logic       alt_en;
    logic [1:0] port_en;
  } cfg_t;
endpackage

// File: rtl/eth_hdr_store.sv
module eth_hdr_store
  import eth_route_pkg::*;
#(
  parameter int UW = 4
) (
  input  logic                               clk,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_idx,
  input  logic [BEAT_W-1:0]                  wr_data,
  input  logic [UW-1:0]                      wr_user,
  input  logic [IDX_W-1:0]                   rd_idx,
  output logic [BEAT_W-1:0]                  rd_data,
  output logic [UW-1:0]                      rd_user,
  output logic [HDR_BEATS-1:0][BEAT_W-1:0]   beats
);
  logic [HDR_BEATS-1:0][UW-1:0] users;

  for (genvar g = 0; g < HDR_BEATS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(g)) begin
        beats[g] <= wr_data;
        users[g] <= wr_user;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    rd_user = '0;
    for (int i = 0; i < HDR_BEATS; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_data = beats[i];
        rd_user = users[i];
      end
    end
  end
endmodule

// File: rtl/eth_route_cfg.sv
module eth_route_cfg
  import eth_route_pkg::*;
#(
  parameter int                 SET_AW   = 8,
  parameter logic [SET_AW-1:0]  SET_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_stb,
  input  logic [SET_AW-1:0] set_addr,
  input  logic [31:0]       set_data,
  output cfg_t              cfg
);
  localparam logic [SET_AW-1:0] ADDR_CTRL  = SET_BASE;
  localparam logic [SET_AW-1:0] ADDR_PORTS = SET_BASE + SET_AW'(1);

  logic unused_hi;
  assign unused_hi = ^set_data[31:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '{strm_en: 1'b1, alt_en: 1'b1, port_en: 2'b11};
    end else if (set_stb) begin
      if (set_addr == ADDR_CTRL) begin
        cfg.strm_en <= set_data[0];
        cfg.alt_en  <= set_data[1];
      end else if (set_addr == ADDR_PORTS) begin
        cfg.port_en <= set_data[1:0];
      end
    end
  end
endmodule

// File: rtl/eth_route_decide.sv
module eth_route_decide
  import eth_route_pkg::*;
#(
  parameter bit DROP_FOREIGN = 1'b0
) (
  input  logic [HDR_BEATS-1:0][BEAT_W-1:0] beats,
  input  logic [IDX_W-1:0]                 n_beats,
  input  logic                             short_frm,
  input  cfg_t                             cfg,
  input  logic [47:0]                      own_mac,
  input  logic [47:0]                      alt_mac,
  input  logic [31:0]                      own_ip,
  input  logic [15:0]                      port_a,
  input  logic [15:0]                      port_b,
  output dest_e                            dest
);
  logic [47:0] dmac;
  logic [15:0] etype;
  logic [7:0]  proto;
  logic [31:0] dip;
  logic [15:0] dport;
  logic        mac_seen, bcast, mac_hit, port_hit, udp_hit;

  assign dmac  = {beats[0][15:0], beats[1][63:32]};
  assign etype = beats[2][47:32];
  assign proto = beats[3][23:16];
  assign dip   = beats[4][31:0];
  assign dport = beats[5][47:32];

  logic unused_hdr;
  assign unused_hdr = ^{beats[0][63:16], beats[1][31:0], beats[2][63:48],
                        beats[2][31:0], beats[3][63:24], beats[3][15:0],
                        beats[4][63:32], beats[5][63:48], beats[5][31:0]};

  assign mac_seen = n_beats >= IDX_W'(2);
  assign bcast    = mac_seen && (dmac == '1);
  assign mac_hit  = mac_seen && ((dmac == own_mac) || (cfg.alt_en && dmac == alt_mac));
  assign port_hit = (cfg.port_en[0] && dport == port_a) ||
                    (cfg.port_en[1] && dport == port_b);
  assign udp_hit  = !short_frm && etype == ETYPE_IPV4 && proto == PROTO_UDP &&
                    dip == own_ip && port_hit;

  always_comb begin
    if (bcast)
      dest = DEST_CPU;
    else if (mac_hit)
      dest = (udp_hit && cfg.strm_en) ? DEST_STRM : DEST_CPU;
    else
      dest = DROP_FOREIGN ? DEST_DROP : DEST_XO;
  end
endmodule

// File: rtl/eth_frame_router.sv
module eth_frame_router
  import eth_route_pkg::*;
#(
  parameter int                UW           = 4,
  parameter int                SET_AW       = 8,
  parameter logic [SET_AW-1:0] SET_BASE     = 8'h40,
  parameter bit                DROP_FOREIGN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_stb,
  input  logic [SET_AW-1:0] set_addr,
  input  logic [31:0]       set_data,
  input  logic [47:0]       own_mac,
  input  logic [47:0]       alt_mac,
  input  logic [31:0]       own_ip,
  input  logic [15:0]       port_a,
  input  logic [15:0]       port_b,
  input  logic [63:0]       in_data,
  input  logic [UW-1:0]     in_user,
  input  logic              in_last,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [63:0]       strm_data,
  output logic              strm_last,
  output logic              strm_valid,
  input  logic              strm_ready,
  output logic [63:0]       cpu_data,
  output logic [UW-1:0]     cpu_user,
  output logic              cpu_last,
  output logic              cpu_valid,
  input  logic              cpu_ready,
  output logic [63:0]       xo_data,
  output logic [UW-1:0]     xo_user,
  output logic              xo_last,
  output logic              xo_valid,
  input  logic              xo_ready
);
  phase_e                          phase;
  logic [IDX_W-1:0]                n_q, rd_q;
  logic                            last_in_hdr;
  dest_e                           route_q, dest_c;
  cfg_t                            cfg;
  logic [HDR_BEATS-1:0][BEAT_W-1:0] hdr_beats;
  logic [BEAT_W-1:0]               hdr_rd_data;
  logic [UW-1:0]                   hdr_rd_user;
  logic                            hdr_wr, hdr_end, rd_end, sel_ready;
  logic                            src_valid, src_last;
  logic [BEAT_W-1:0]               src_data;
  logic [UW-1:0]                   src_user;

  assign hdr_wr  = (phase == S_CAPT) && in_valid;
  assign hdr_end = in_last || (n_q == IDX_W'(HDR_BEATS - 1));
  assign rd_end  = (rd_q == n_q - IDX_W'(1));

  eth_hdr_store #(.UW(UW)) u_store (
    .clk     (clk),
    .wr_en   (hdr_wr),
    .wr_idx  (n_q),
    .wr_data (in_data),
    .wr_user (in_user),
    .rd_idx  (rd_q),
    .rd_data (hdr_rd_data),
    .rd_user (hdr_rd_user),
    .beats   (hdr_beats)
  );

  eth_route_cfg #(.SET_AW(SET_AW), .SET_BASE(SET_BASE)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .set_stb  (set_stb),
    .set_addr (set_addr),
    .set_data (set_data),
    .cfg      (cfg)
  );

  eth_route_decide #(.DROP_FOREIGN(DROP_FOREIGN)) u_decide (
    .beats     (hdr_beats),
    .n_beats   (n_q),
    .short_frm (last_in_hdr),
    .cfg       (cfg),
    .own_mac   (own_mac),
    .alt_mac   (alt_mac),
    .own_ip    (own_ip),
    .port_a    (port_a),
    .port_b    (port_b),
    .dest      (dest_c)
  );

  always_comb begin
    case (route_q)
      DEST_STRM: sel_ready = strm_ready;
      DEST_CPU:  sel_ready = cpu_ready;
      DEST_XO:   sel_ready = xo_ready;
      default:   sel_ready = 1'b1;
    endcase
  end

  always_comb begin
    src_valid = 1'b0;
    src_data  = hdr_rd_data;
    src_user  = hdr_rd_user;
    src_last  = 1'b0;
    in_ready  = 1'b0;
    case (phase)
      S_CAPT: in_ready = 1'b1;
      S_REPLAY: begin
        src_valid = 1'b1;
        src_last  = last_in_hdr && rd_end;
      end
      S_PASS: begin
        src_valid = in_valid && (route_q != DEST_DROP);
        src_data  = in_data;
        src_user  = in_user;
        src_last  = in_last;
        in_ready  = sel_ready;
      end
      default: ;
    endcase
  end

  assign strm_valid = src_valid && (route_q == DEST_STRM);
  assign cpu_valid  = src_valid && (route_q == DEST_CPU);
  assign xo_valid   = src_valid && (route_q == DEST_XO);
  assign strm_data  = src_data;
  assign cpu_data   = src_data;
  assign xo_data    = src_data;
  assign strm_last  = src_last;
  assign cpu_last   = src_last;
  assign xo_last    = src_last;
  assign cpu_user   = src_user;
  assign xo_user    = src_user;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= S_CAPT;
      n_q         <= '0;
      rd_q        <= '0;
      last_in_hdr <= 1'b0;
      route_q     <= DEST_CPU;
    end else begin
      case (phase)
        S_CAPT: begin
          if (in_valid) begin
            n_q <= n_q + IDX_W'(1);
            if (hdr_end) begin
              last_in_hdr <= in_last;
              phase       <= S_DECIDE;
            end
          end
        end
        S_DECIDE: begin
          route_q <= dest_c;
          rd_q    <= '0;
          if (dest_c == DEST_STRM) begin
            phase <= S_PASS;
          end else if (dest_c == DEST_DROP) begin
            if (last_in_hdr) begin
              phase <= S_CAPT;
              n_q   <= '0;
            end else begin
              phase <= S_PASS;
            end
          end else begin
            phase <= S_REPLAY;
          end
        end
        S_REPLAY: begin
          if (sel_ready) begin
            if (rd_end) begin
              if (last_in_hdr) begin
                phase <= S_CAPT;
                n_q   <= '0;
              end else begin
                phase <= S_PASS;
              end
            end else begin
              rd_q <= rd_q + IDX_W'(1);
            end
          end
        end
        S_PASS: begin
          if (in_valid && in_ready && in_last) begin
            phase <= S_CAPT;
            n_q   <= '0;
          end
        end
        default: phase <= S_CAPT;
      endcase
    end
  end
endmodule

// File: rtl/eth_frame_router_chk.sv
module eth_frame_router_chk #(
  parameter int UW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic [63:0]   strm_data,
  input logic          strm_last,
  input logic          strm_valid,
  input logic          strm_ready,
  input logic [63:0]   cpu_data,
  input logic [UW-1:0] cpu_user,
  input logic          cpu_last,
  input logic          cpu_valid,
  input logic          cpu_ready,
  input logic [63:0]   xo_data,
  input logic [UW-1:0] xo_user,
  input logic          xo_last,
  input logic          xo_valid,
  input logic          xo_ready
);
  // R1
  rst_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!strm_valid && !cpu_valid && !xo_valid && in_ready));

  // R8
  one_dest_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strm_valid, cpu_valid, xo_valid}));

  // R8
  strm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strm_valid && !strm_ready) |=> (strm_valid && $stable(strm_data) && $stable(strm_last)));

  // R8
  cpu_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && !cpu_ready) |=>
      (cpu_valid && $stable(cpu_data) && $stable(cpu_user) && $stable(cpu_last)));

  // R8
  xo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (xo_valid && !xo_ready) |=>
      (xo_valid && $stable(xo_data) && $stable(xo_user) && $stable(xo_last)));

  // R8
  stall_in_chk: assert property (@(posedge clk) disable iff (rst)
    ((strm_valid && !strm_ready) || (cpu_valid && !cpu_ready) || (xo_valid && !xo_ready))
      |-> !in_ready);
endmodule

bind eth_frame_router eth_frame_router_chk #(.UW(UW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .strm_data  (strm_data),
  .strm_last  (strm_last),
  .strm_valid (strm_valid),
  .strm_ready (strm_ready),
  .cpu_data   (cpu_data),
  .cpu_user   (cpu_user),
  .cpu_last   (cpu_last),
  .cpu_valid  (cpu_valid),
  .cpu_ready  (cpu_ready),
  .xo_data    (xo_data),
  .xo_user    (xo_user),
  .xo_last    (xo_last),
  .xo_valid   (xo_valid),
  .xo_ready   (xo_ready)
);

// File: tb/eth_frame_router_tb.sv
`timescale 1ns/1ps
module eth_frame_router_tb;
  localparam logic [7:0]  BASE   = 8'h40;
  localparam logic [47:0] MAC_A  = 48'h0200_0000_0001;
  localparam logic [47:0] MAC_B  = 48'h0200_0000_0002;
  localparam logic [47:0] MAC_F  = 48'h0200_0000_0077;
  localparam logic [31:0] IP_OWN = 32'hC0A8_0001;
  localparam logic [15:0] PA     = 16'd5000;
  localparam logic [15:0] PB     = 16'd5001;
  localparam logic [1:0]  TO_STRM = 2'd0, TO_CPU = 2'd1, TO_XO = 2'd2;

  typedef struct packed {
    logic [1:0]  dsel;   // 0 own, 1 bridge, 2 broadcast, 3 foreign
    logic [15:0] etype;
    logic [7:0]  proto;
    logic        ipok;
    logic [1:0]  psel;   // 0 port_a, 1 port_b, 2 other
    logic [5:0]  len;
    logic [1:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 12;
  localparam logic [40:0] VEC [0:NVEC-1] = '{
    {2'd0, 16'h0800, 8'd17, 1'b1, 2'd0, 6'd9, 2'd0, 4'd2},  // R2 own MAC, port_a
    {2'd1, 16'h0800, 8'd17, 1'b1, 2'd1, 6'd8, 2'd0, 4'd2},  // R2 bridge MAC, port_b
    {2'd0, 16'h0806, 8'd17, 1'b1, 2'd0, 6'd8, 2'd1, 4'd3},  // R3 wrong ethertype
    {2'd0, 16'h0800, 8'd6,  1'b1, 2'd0, 6'd8, 2'd1, 4'd3},  // R3 wrong protocol
    {2'd0, 16'h0800, 8'd17, 1'b0, 2'd0, 6'd8, 2'd1, 4'd3},  // R3 wrong IP
    {2'd0, 16'h0800, 8'd17, 1'b1, 2'd2, 6'd7, 2'd1, 4'd3},  // R3 wrong port
    {2'd2, 16'h0800, 8'd17, 1'b1, 2'd0, 6'd8, 2'd1, 4'd4},  // R4 broadcast
    {2'd3, 16'h0800, 8'd17, 1'b1, 2'd0, 6'd8, 2'd2, 4'd5},  // R5 foreign
    {2'd0, 16'h0800, 8'd17, 1'b1, 2'd0, 6'd6, 2'd1, 4'd10}, // R10 header only
    {2'd0, 16'h0800, 8'd17, 1'b1, 2'd0, 6'd3, 2'd1, 4'd10}, // R10 three beats
    {2'd0, 16'h0800, 8'd17, 1'b1, 2'd0, 6'd1, 2'd2, 4'd10}, // R10 one beat
    {2'd0, 16'h0800, 8'd17, 1'b1, 2'd0, 6'd7, 2'd0, 4'd2}   // R2 one payload beat
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        set_stb = 1'b0;
  logic [7:0]  set_addr = '0;
  logic [31:0] set_data = '0;
  logic [63:0] in_data = '0;
  logic [3:0]  in_user = '0;
  logic        in_last = 1'b0, in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] strm_data, cpu_data, xo_data;
  logic [3:0]  cpu_user, xo_user;
  logic        strm_last, strm_valid, cpu_last, cpu_valid, xo_last, xo_valid;
  logic        strm_ready = 1'b1, cpu_ready = 1'b1, xo_ready = 1'b1;

  eth_frame_router #(.UW(4), .SET_AW(8), .SET_BASE(BASE), .DROP_FOREIGN(1'b0)) u_dut (
    .clk(clk), .rst(rst), .set_stb(set_stb), .set_addr(set_addr), .set_data(set_data),
    .own_mac(MAC_A), .alt_mac(MAC_B), .own_ip(IP_OWN), .port_a(PA), .port_b(PB),
    .in_data(in_data), .in_user(in_user), .in_last(in_last), .in_valid(in_valid),
    .in_ready(in_ready),
    .strm_data(strm_data), .strm_last(strm_last), .strm_valid(strm_valid),
    .strm_ready(strm_ready),
    .cpu_data(cpu_data), .cpu_user(cpu_user), .cpu_last(cpu_last), .cpu_valid(cpu_valid),
    .cpu_ready(cpu_ready),
    .xo_data(xo_data), .xo_user(xo_user), .xo_last(xo_last), .xo_valid(xo_valid),
    .xo_ready(xo_ready)
  );

  int checks = 0, failures = 0;
  int fid = 0;

  // ready pattern generator
  int          bp_mode = 0;
  logic        hold_strm = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (bp_mode == 0) begin
      strm_ready = 1'b1; cpu_ready = 1'b1; xo_ready = 1'b1;
    end else begin
      strm_ready = lfsr[0]; cpu_ready = lfsr[3]; xo_ready = lfsr[7];
    end
    if (hold_strm) strm_ready = 1'b0;
  end

  // output capture
  logic [63:0] s_d [0:1023];
  logic        s_l [0:1023];
  logic [63:0] c_d [0:1023];
  logic [3:0]  c_u [0:1023];
  logic        c_l [0:1023];
  logic [63:0] x_d [0:1023];
  logic [3:0]  x_u [0:1023];
  logic        x_l [0:1023];
  int s_n = 0, c_n = 0, x_n = 0;
  always @(negedge clk) begin
    if (strm_valid && strm_ready && s_n < 1024) begin
      s_d[s_n] = strm_data; s_l[s_n] = strm_last; s_n++;
    end
    if (cpu_valid && cpu_ready && c_n < 1024) begin
      c_d[c_n] = cpu_data; c_u[c_n] = cpu_user; c_l[c_n] = cpu_last; c_n++;
    end
    if (xo_valid && xo_ready && x_n < 1024) begin
      x_d[x_n] = xo_data; x_u[x_n] = xo_user; x_l[x_n] = xo_last; x_n++;
    end
  end

  // frame under test
  logic [63:0] fr_d [0:31];
  logic [3:0]  fr_u [0:31];
  int          fr_n;

  task automatic chk(input bit ok, input string tag, input logic [63:0] got,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic build(input vec_t v);
    logic [47:0] dmac;
    logic [31:0] dip;
    logic [15:0] dport;
    logic [63:0] hdr [0:5];
    fid++;
    case (v.dsel)
      2'd0: dmac = MAC_A;
      2'd1: dmac = MAC_B;
      2'd2: dmac = 48'hFFFF_FFFF_FFFF;
      default: dmac = MAC_F;
    endcase
    dip   = v.ipok ? IP_OWN : 32'hC0A8_0063;
    dport = (v.psel == 2'd0) ? PA : (v.psel == 2'd1) ? PB : 16'd6000;
    hdr[0] = {48'h0, dmac[47:32]};
    hdr[1] = {dmac[31:0], 32'h0200_0000};
    hdr[2] = {16'h00AA, v.etype, 32'h4500_0030};
    hdr[3] = {16'h1234, 16'h0000, 8'h40, v.proto, 16'h0000};
    hdr[4] = {32'hC0A8_0005, dip};
    hdr[5] = {16'h1111, dport, 16'h0018, 16'h0000};
    fr_n = int'(v.len);
    for (int i = 0; i < fr_n; i++) begin
      if (i < 6) fr_d[i] = hdr[i];
      else fr_d[i] = {8'hD0, 8'(fid), 16'(i), 32'h5A5A_0000 + 32'(i)};
      fr_u[i] = 4'(i) ^ 4'(fid);
    end
  endtask

  task automatic send;
    for (int i = 0; i < fr_n; i++) begin
      in_data = fr_d[i]; in_user = fr_u[i]; in_last = (i == fr_n - 1); in_valid = 1'b1;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic write_cfg(input logic [7:0] a, input logic [31:0] d);
    set_stb = 1'b1; set_addr = a; set_data = d;
    @(posedge clk); #1;
    set_stb = 1'b0;
  endtask

  task automatic verify(input logic [1:0] exp, input string tag,
                        input int sb, input int cb, input int xb);
    bit ok;
    logic [63:0] g, e;
    int route;
    ok = 1'b1; g = '0; e = '0;
    route = (s_n > sb) ? 0 : (c_n > cb) ? 1 : (x_n > xb) ? 2 : 3;
    if (exp == TO_STRM) begin
      if (s_n - sb != fr_n - 6 || c_n != cb || x_n != xb) begin
        ok = 1'b0; g = 64'(route); e = 64'(exp);
      end else begin
        for (int k = 0; k < fr_n - 6; k++)
          if (ok && (s_d[sb+k] != fr_d[6+k] || s_l[sb+k] != (k == fr_n - 7))) begin
            ok = 1'b0; g = s_d[sb+k]; e = fr_d[6+k];
          end
      end
    end else if (exp == TO_CPU) begin
      if (c_n - cb != fr_n || s_n != sb || x_n != xb) begin
        ok = 1'b0; g = 64'(route); e = 64'(exp);
      end else begin
        for (int k = 0; k < fr_n; k++)
          if (ok && (c_d[cb+k] != fr_d[k] || c_u[cb+k] != fr_u[k] ||
                     c_l[cb+k] != (k == fr_n - 1))) begin
            ok = 1'b0; g = c_d[cb+k]; e = fr_d[k];
          end
      end
    end else begin
      if (x_n - xb != fr_n || s_n != sb || c_n != cb) begin
        ok = 1'b0; g = 64'(route); e = 64'(exp);
      end else begin
        for (int k = 0; k < fr_n; k++)
          if (ok && (x_d[xb+k] != fr_d[k] || x_u[xb+k] != fr_u[k] ||
                     x_l[xb+k] != (k == fr_n - 1))) begin
            ok = 1'b0; g = x_d[xb+k]; e = fr_d[k];
          end
      end
    end
    chk(ok, tag, g, e);
  endtask

  task automatic run(input vec_t v, input string tag);
    int sb, cb, xb;
    sb = s_n; cb = c_n; xb = x_n;
    build(v);
    send();
    repeat (80) @(posedge clk);
    @(negedge clk);
    verify(v.exp, tag, sb, cb, xb);
    @(posedge clk); #1;
  endtask

  function automatic vec_t mk(input logic [1:0] dsel, input logic [1:0] psel,
                              input logic [5:0] len, input logic [1:0] exp);
    vec_t v;
    v.dsel = dsel; v.etype = 16'h0800; v.proto = 8'd17; v.ipok = 1'b1;
    v.psel = psel; v.len = len; v.exp = exp; v.req = 4'd0;
    return v;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL R8 watchdog: got hung run, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    vec_t v;
    int sb, cb, xb;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!strm_valid && !cpu_valid && !xo_valid && in_ready, "R1 reset outputs",
        {60'h0, strm_valid, cpu_valid, xo_valid, in_ready}, 64'h1);
    @(posedge clk); #1;

    // table walk (R2 R3 R4 R5 R10)
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      run(v, $sformatf("R%0d vector %0d", v.req, i));
    end

    // R6 payload path off, then bridge match off
    write_cfg(BASE, 32'h2);
    run(mk(2'd0, 2'd0, 6'd8, TO_CPU), "R6 payload path disabled");
    write_cfg(BASE, 32'h1);
    run(mk(2'd1, 2'd0, 6'd8, TO_XO), "R6 bridge match disabled");
    write_cfg(BASE, 32'h3);

    // R7 port enables and unused address
    write_cfg(BASE + 8'd1, 32'h2);
    run(mk(2'd0, 2'd0, 6'd8, TO_CPU), "R7 port_a disabled");
    run(mk(2'd0, 2'd1, 6'd8, TO_STRM), "R7 port_b still enabled");
    write_cfg(BASE + 8'd1, 32'h3);
    write_cfg(BASE + 8'd2, 32'h0);
    run(mk(2'd0, 2'd0, 6'd8, TO_STRM), "R7 write to other address ignored");

    // R8 / R9 stalled payload sink with a settings write mid-frame
    sb = s_n; cb = c_n; xb = x_n;
    hold_strm = 1'b1;
    build(mk(2'd0, 2'd0, 6'd10, TO_STRM));
    fork
      send();
      begin
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk(!in_ready && strm_valid, "R8 stalled sink holds off input",
            {62'h0, in_ready, strm_valid}, 64'h1);
        @(posedge clk); #1;
        write_cfg(BASE, 32'h2);
        hold_strm = 1'b0;
      end
    join
    repeat (80) @(posedge clk);
    @(negedge clk);
    verify(TO_STRM, "R9 route kept after mid-frame write", sb, cb, xb);
    @(posedge clk); #1;
    write_cfg(BASE, 32'h3);

    // R8 random ready patterns on all sinks
    bp_mode = 1;
    run(mk(2'd0, 2'd1, 6'd12, TO_STRM), "R8 random ready payload");
    run(mk(2'd2, 2'd0, 6'd9, TO_CPU), "R8 random ready cpu");
    run(mk(2'd3, 2'd0, 6'd11, TO_XO), "R8 random ready crossover");
    run(mk(2'd0, 2'd0, 6'd4, TO_CPU), "R8 random ready short frame");
    bp_mode = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule